// File: doc/BRIEF.md
# Sequential Non-Restoring Integer Divider

This block divides a 32-bit dividend by a 32-bit divisor one quotient bit per clock, using non-restoring add/subtract steps on a signed partial remainder. A start pulse captures the operands together with a signed/unsigned select, a halfword select and a 4-bit step field. The step field sets the quotient length N: a zero field asks for a full 32-bit divide, and any other value shortens the quotient to 32 minus twice the field. Shorter quotients finish sooner, and results that do not fit in N bits are reported as overflow.

In signed mode the divider works on magnitudes and then applies the signs. The quotient truncates toward zero and the remainder takes the sign of the dividend. With the halfword select set, only the low 16 bits of the divisor are used. After the last step a single correction cycle restores a negative partial remainder, applies the signs, substitutes the overflow result and forms the zero and sign flags. A one-cycle done pulse then marks the results, which stay unchanged until the next division completes.

Top module: `seq_nr_divider`

## Requirements
- R1: A clock edge with `rst_n` low clears `busy`, `done`, `quotient`, `remainder`, `ovf`, `zero_flag` and `sign_flag` to 0.
- R2: The quotient length N is 32 when `step_sel` is 0, and 32 - 2*`step_sel` otherwise. `done` is high for exactly one cycle, N+1 clock edges after the edge that accepts `start`. `busy` is high from the accepting edge until the edge that raises `done`.
- R3: In unsigned mode (`signed_mode`=0) without overflow, `quotient` = floor(dividend/divisor) and `remainder` = dividend mod divisor.
- R4: In unsigned mode, overflow occurs when the divisor is 0 or when the true quotient is at least 2^N. On overflow `ovf`=1, `quotient` equals the dividend and `remainder` is 0.
- R5: In signed mode (`signed_mode`=1) without overflow, operands are two's complement, the quotient is truncated toward zero, and the remainder has the sign of the dividend.
- R6: In signed mode, overflow occurs when the divisor is 0 or when the true quotient lies outside [-2^(N-1), 2^(N-1)-1]. For N=32 this includes the most negative value divided by -1. The outputs on overflow are as in R4.
- R7: With `half_sel`=1, only `divisor[15:0]` is used: zero-extended in unsigned mode and sign-extended from bit 15 in signed mode. `divisor[31:16]` has no effect.
- R8: `zero_flag` is 1 exactly when the delivered `quotient` is 0, and `sign_flag` equals bit 31 of the delivered `quotient`. Both follow any overflow substitution.
- R9: A `start` while `busy` is high is ignored. The running division keeps its operands and produces a single `done`.
- R10: `quotient`, `remainder`, `ovf` and both flags hold their values in every cycle except the one in which `done` delivers a new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a division when idle |
| dividend | input | 32 | Dividend |
| divisor | input | 32 | Divisor |
| signed_mode | input | 1 | 1: two's complement operands |
| half_sel | input | 1 | 1: use only the low 16 bits of the divisor |
| step_sel | input | 4 | Quotient length select (0 = 32 bits) |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse, results valid |
| quotient | output | 32 | Quotient, or the dividend on overflow |
| remainder | output | 32 | Remainder, or 0 on overflow |
| ovf | output | 1 | Overflow or divide by zero |
| zero_flag | output | 1 | Delivered quotient is zero |
| sign_flag | output | 1 | Bit 31 of the delivered quotient |

## Verification
The bench targets the boundary where the quotient just fits in N bits and the boundary where it just fails to fit, for every value of the step field. A wrong length decode or a wrong overflow compare shows up as a valid-looking quotient where overflow was due, or the reverse. It also covers a zero divisor, the most negative dividend over -1, and signed operand pairs with mixed signs. A design that mishandled these would deliver a quotient with the wrong sign, a remainder carrying the divisor's sign, or a remainder still negative because the final add-back was missed. Halfword divisors with live upper bits catch a missing mask or sign extension. A start pulse injected during a run catches a design that reloads its operands while busy.

// File: rtl/nrdiv_pkg.sv
// Shared types for the sequential non-restoring divider.
// Assumes: nothing beyond a single clock domain.
package nrdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } nrdiv_state_e;
endpackage

// File: rtl/nrdiv_prep.sv
// Operand preparation: narrows the divisor for halfword requests, takes
// magnitudes in signed mode, decodes the quotient length, and predicts
// range overflow before the first step.
// Assumes: W > 2*(2**SFW - 1), so the shortest quotient length is positive.
module nrdiv_prep #(
    parameter int W   = 32,
    parameter int HW  = 16,
    parameter int SFW = 4,
    parameter int CW  = $clog2(W + 1)
) (
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    input  logic           sgn,
    input  logic           half,
    input  logic [SFW-1:0] step_sel,
    output logic [W-1:0]   a_mag,
    output logic [W-1:0]   b_mag,
    output logic [CW-1:0]  nbits,
    output logic           neg_q,
    output logic           neg_r,
    output logic           zero_div,
    output logic           range_ov
);
    logic [W-1:0] b_eff;
    logic         a_neg;
    logic         b_neg;

    // Narrow the divisor, take magnitudes and decode the quotient length.
    always_comb begin
        if (half)
            b_eff = sgn ? {{(W-HW){b_in[HW-1]}}, b_in[HW-1:0]}
                        : {{(W-HW){1'b0}}, b_in[HW-1:0]};
        else
            b_eff = b_in;
        a_neg    = sgn & a_in[W-1];
        b_neg    = sgn & b_eff[W-1];
        a_mag    = a_neg ? (~a_in + 1'b1) : a_in;
        b_mag    = b_neg ? (~b_eff + 1'b1) : b_eff;
        nbits    = (step_sel == '0) ? CW'(W) : CW'(W - 2 * int'(step_sel));
        neg_q    = a_neg ^ b_neg;
        neg_r    = a_neg;
        zero_div = (b_eff == '0);
        range_ov = ((a_mag >> nbits) >= b_mag);
    end
endmodule

// File: rtl/nrdiv_step.sv
// One non-restoring step: shift the partial remainder left taking in the next
// dividend bit, then subtract the divisor when the remainder is non-negative
// (previous quotient bit 1) or add it when negative. The new quotient bit is
// 1 when the result is non-negative.
// Assumes: PW >= W + 2 so the shifted remainder never wraps on valid inputs.
module nrdiv_step #(
    parameter int W  = 32,
    parameter int PW = W + 3
) (
    input  logic [PW-1:0] p_in,
    input  logic [W-1:0]  d_in,
    input  logic          bit_in,
    output logic [PW-1:0] p_out,
    output logic          q_bit
);
    logic [PW-1:0] shifted;
    logic [PW-1:0] d_ext;

    // Add or subtract the divisor according to the current remainder sign.
    always_comb begin
        shifted = {p_in[PW-2:0], bit_in};
        d_ext   = {{(PW-W){1'b0}}, d_in};
        p_out   = p_in[PW-1] ? (shifted + d_ext) : (shifted - d_ext);
        q_bit   = ~p_out[PW-1];
    end
endmodule

// File: rtl/nrdiv_fix.sv
// Final correction: add the divisor back to a negative remainder, apply the
// signs, check signed range, substitute the overflow result and form flags.
// Assumes: qmag is valid whenever range_ov is clear.
module nrdiv_fix #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  p_low,
    input  logic          p_neg,
    input  logic [W-1:0]  d_in,
    input  logic [W-1:0]  qmag,
    input  logic [W-1:0]  a_raw,
    input  logic [CW-1:0] nbits,
    input  logic          sgn,
    input  logic          neg_q,
    input  logic          neg_r,
    input  logic          zero_div,
    input  logic          range_ov,
    output logic [W-1:0]  q_out,
    output logic [W-1:0]  r_out,
    output logic          ov_out,
    output logic          z_out,
    output logic          s_out
);
    logic [W-1:0] rmag;
    logic [W:0]   half_pt;
    logic         mag_ov;

    // Correct the remainder, apply signs and resolve overflow.
    always_comb begin
        rmag    = p_neg ? (p_low + d_in) : p_low;
        half_pt = (W+1)'(1) << (nbits - CW'(1));
        mag_ov  = neg_q ? ({1'b0, qmag} > half_pt) : ({1'b0, qmag} >= half_pt);
        ov_out  = zero_div | range_ov | (sgn & mag_ov);
        if (ov_out) begin
            q_out = a_raw;
            r_out = '0;
        end else begin
            q_out = neg_q ? (~qmag + 1'b1) : qmag;
            r_out = neg_r ? (~rmag + 1'b1) : rmag;
        end
        z_out = (q_out == '0);
        s_out = q_out[W-1];
    end
endmodule

// File: rtl/seq_nr_divider.sv
// Sequential divider top: accepts a start when idle, runs N non-restoring
// steps (one per clock), spends one cycle on correction, then pulses done.
// Results hold until the next division completes; start is ignored while busy.
// Assumes: synchronous active-low reset, single clock.
module seq_nr_divider #(
    parameter int W   = 32,
    parameter int HW  = 16,
    parameter int SFW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   dividend,
    input  logic [W-1:0]   divisor,
    input  logic           signed_mode,
    input  logic           half_sel,
    input  logic [SFW-1:0] step_sel,
    output logic           busy,
    output logic           done,
    output logic [W-1:0]   quotient,
    output logic [W-1:0]   remainder,
    output logic           ovf,
    output logic           zero_flag,
    output logic           sign_flag
);
    import nrdiv_pkg::*;

    localparam int CW = $clog2(W + 1);
    localparam int PW = W + 3;

    nrdiv_state_e  state;
    logic [CW-1:0] cnt;
    logic [PW-1:0] p_r;
    logic [W-1:0]  d_r, abits, qmag, a_raw_r;
    logic [CW-1:0] nbits_r;
    logic          sgn_r, neg_q_r, neg_r_r, zdiv_r, rov_r;

    logic [W-1:0]  a_mag, b_mag;
    logic [CW-1:0] nbits;
    logic          neg_q, neg_r, zero_div, range_ov;
    logic [PW-1:0] p_next;
    logic          q_bit;
    logic [W-1:0]  q_fix, r_fix;
    logic          ov_fix, z_fix, s_fix;

    nrdiv_prep #(.W(W), .HW(HW), .SFW(SFW), .CW(CW)) u_prep (
        .a_in(dividend), .b_in(divisor), .sgn(signed_mode), .half(half_sel),
        .step_sel(step_sel), .a_mag(a_mag), .b_mag(b_mag), .nbits(nbits),
        .neg_q(neg_q), .neg_r(neg_r), .zero_div(zero_div), .range_ov(range_ov)
    );

    nrdiv_step #(.W(W), .PW(PW)) u_step (
        .p_in(p_r), .d_in(d_r), .bit_in(abits[W-1]), .p_out(p_next), .q_bit(q_bit)
    );

    nrdiv_fix #(.W(W), .CW(CW)) u_fix (
        .p_low(p_r[W-1:0]), .p_neg(p_r[PW-1]), .d_in(d_r), .qmag(qmag),
        .a_raw(a_raw_r), .nbits(nbits_r), .sgn(sgn_r), .neg_q(neg_q_r),
        .neg_r(neg_r_r), .zero_div(zdiv_r), .range_ov(rov_r),
        .q_out(q_fix), .r_out(r_fix), .ov_out(ov_fix), .z_out(z_fix), .s_out(s_fix)
    );

    assign busy = (state != ST_IDLE);

    // Sequencer: load operands, step once per clock, then correct and deliver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            p_r       <= '0;
            d_r       <= '0;
            abits     <= '0;
            qmag      <= '0;
            a_raw_r   <= '0;
            nbits_r   <= CW'(W);
            sgn_r     <= 1'b0;
            neg_q_r   <= 1'b0;
            neg_r_r   <= 1'b0;
            zdiv_r    <= 1'b0;
            rov_r     <= 1'b0;
            done      <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
            ovf       <= 1'b0;
            zero_flag <= 1'b0;
            sign_flag <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        p_r     <= {{(PW-W){1'b0}}, a_mag >> nbits};
                        abits   <= a_mag << (W - int'(nbits));
                        d_r     <= b_mag;
                        qmag    <= '0;
                        a_raw_r <= dividend;
                        nbits_r <= nbits;
                        cnt     <= nbits;
                        sgn_r   <= signed_mode;
                        neg_q_r <= neg_q;
                        neg_r_r <= neg_r;
                        zdiv_r  <= zero_div;
                        rov_r   <= range_ov;
                        state   <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    p_r   <= p_next;
                    abits <= abits << 1;
                    qmag  <= {qmag[W-2:0], q_bit};
                    cnt   <= cnt - CW'(1);
                    if (cnt == CW'(1))
                        state <= ST_FIN;
                end
                default: begin
                    quotient  <= q_fix;
                    remainder <= r_fix;
                    ovf       <= ov_fix;
                    zero_flag <= z_fix;
                    sign_flag <= s_fix;
                    done      <= 1'b1;
                    state     <= ST_IDLE;
                end
            endcase
        end
    end

    // done is a single-cycle pulse (R2)
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // an accepted start makes the unit busy on the next cycle (R2)
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // a step cycle never runs with an exhausted count (R2)
    assert_run_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (cnt != '0));

    // valid unsigned result leaves a remainder below the divisor (R3)
    assert_rem_below_divisor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ovf && !sgn_r) |-> (remainder < d_r));

    // start during a division does not disturb the captured divisor (R9)
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(d_r));

    // results change only together with done (R10)
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && $past(rst_n)) |-> ($stable(quotient) && $stable(remainder) && $stable(ovf)));
endmodule

// File: tb/test_seq_nr_divider.sv
`timescale 1ns/1ps
module test_seq_nr_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] dividend = '0, divisor = '0;
    logic        signed_mode = 1'b0, half_sel = 1'b0;
    logic [3:0]  step_sel = '0;
    logic        busy, done, ovf, zero_flag, sign_flag;
    logic [31:0] quotient, remainder;

    always #2 clk = ~clk;

    seq_nr_divider i_seq_nr_divider (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .signed_mode(signed_mode), .half_sel(half_sel),
        .step_sel(step_sel), .busy(busy), .done(done), .quotient(quotient),
        .remainder(remainder), .ovf(ovf), .zero_flag(zero_flag), .sign_flag(sign_flag)
    );

    int total = 0;
    int bad = 0;
    bit checking = 1'b0;
    bit cur_r9 = 1'b0;

    // reference model state
    int          m_cnt = 0;
    bit          m_done = 1'b0;
    logic [31:0] p_q = '0, p_r = '0, e_q = '0, e_r = '0;
    bit          p_ov = 1'b0, e_ov = 1'b0;
    string       p_tag = "R3", e_tag = "R3";

    function automatic int qlen(input logic [3:0] st);
        return (st == 0) ? 32 : 32 - 2 * int'(st);
    endfunction

    // Behavioural reference division from the requirements.
    function automatic void ref_div(input logic [31:0] a, input logic [31:0] b,
                                    input bit sg, input bit hf, input logic [3:0] st,
                                    output logic [31:0] q, output logic [31:0] r,
                                    output bit ov);
        int          n;
        logic [31:0] be;
        longint      sa, sb, qt, rt, lim;
        n  = qlen(st);
        be = hf ? (sg ? {{16{b[15]}}, b[15:0]} : {16'h0, b[15:0]}) : b;
        qt = 0;
        rt = 0;
        if (sg) begin
            sa = longint'($signed(a));
            sb = longint'($signed(be));
            lim = longint'(1) <<< (n - 1);
            if (sb == 0) ov = 1'b1;
            else begin
                qt = sa / sb;
                rt = sa % sb;
                ov = (qt > lim - 1) || (qt < -lim);
            end
        end else begin
            sa = longint'({32'h0, a});
            sb = longint'({32'h0, be});
            if (sb == 0) ov = 1'b1;
            else begin
                qt = sa / sb;
                rt = sa % sb;
                ov = (qt >= (longint'(1) <<< n));
            end
        end
        if (ov) begin
            q = a;
            r = '0;
        end else begin
            q = qt[31:0];
            r = rt[31:0];
        end
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Cycle model of the handshake and the expected results.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_done = 1'b0;
            e_q = '0; e_r = '0; e_ov = 1'b0;
        end else if (m_cnt > 0) begin
            m_cnt--;
            m_done = (m_cnt == 0);
            if (m_done) begin
                e_q = p_q; e_r = p_r; e_ov = p_ov; e_tag = p_tag;
            end
        end else begin
            m_done = 1'b0;
            if (start) begin
                ref_div(dividend, divisor, signed_mode, half_sel, step_sel, p_q, p_r, p_ov);
                m_cnt = qlen(step_sel) + 1;
                if (cur_r9) p_tag = "R9";
                else if (p_ov) p_tag = signed_mode ? "R6" : "R4";
                else if (half_sel) p_tag = "R7";
                else p_tag = signed_mode ? "R5" : "R3";
            end
        end
    end

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (checking) begin
            chk("R2", "busy", {31'h0, busy}, {31'h0, (m_cnt > 0)});
            chk("R2", "done", {31'h0, done}, {31'h0, m_done});
            if (m_done) begin
                chk(e_tag, "quotient", quotient, e_q);
                chk(e_tag, "remainder", remainder, e_r);
                chk(e_tag, "ovf", {31'h0, ovf}, {31'h0, e_ov});
                chk("R8", "zero_flag", {31'h0, zero_flag}, {31'h0, (e_q == 0)});
                chk("R8", "sign_flag", {31'h0, sign_flag}, {31'h0, e_q[31]});
            end else begin
                chk("R10", "held quotient", quotient, e_q);
                chk("R10", "held remainder", remainder, e_r);
                chk("R10", "held ovf", {31'h0, ovf}, {31'h0, e_ov});
            end
        end
    end

    task automatic check_reset_state();
        chk("R1", "busy", {31'h0, busy}, 32'h0);
        chk("R1", "done", {31'h0, done}, 32'h0);
        chk("R1", "quotient", quotient, 32'h0);
        chk("R1", "remainder", remainder, 32'h0);
        chk("R1", "flags", {29'h0, ovf, zero_flag, sign_flag}, 32'h0);
    endtask

    task automatic do_op(input logic [31:0] a, input logic [31:0] b, input bit sg,
                         input bit hf, input logic [3:0] st, input bit inject);
        @(negedge clk);
        dividend = a; divisor = b; signed_mode = sg; half_sel = hf; step_sel = st;
        cur_r9 = inject; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            repeat (2) @(negedge clk);
            dividend = ~a; divisor = b + 32'd1; signed_mode = ~sg; step_sel = 4'd0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (m_cnt != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        cur_r9 = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();                               // R1
        @(negedge clk);
        rst_n = 1'b1;
        checking = 1'b1;

        // directed corners
        do_op(32'd100, 32'd7, 0, 0, 4'd0, 0);              // R3
        do_op(32'd0, 32'd5, 0, 0, 4'd0, 0);                // R3, R8 zero
        do_op(32'hFFFF_FFFF, 32'd1, 0, 0, 4'd0, 0);        // R3, R8 sign
        do_op(32'd1234, 32'd0, 0, 0, 4'd0, 0);             // R4 divide by zero
        do_op(32'h8000_0000, 32'hFFFF_FFFF, 1, 0, 4'd0, 0); // R6 most negative / -1
        do_op(32'hFFFF_FFF9, 32'd2, 1, 0, 4'd0, 0);        // R5 -7/2
        do_op(32'd7, 32'hFFFF_FFFE, 1, 0, 4'd0, 0);        // R5 7/-2
        do_op(32'd100, 32'hFFFF_0003, 0, 1, 4'd0, 0);      // R7 mask upper half
        do_op(32'd100, 32'h0000_FFFE, 1, 1, 4'd0, 0);      // R7 sign-extend
        do_op(32'd7, 32'd2, 0, 0, 4'd15, 0);               // R3 N=2 fits
        do_op(32'd8, 32'd2, 0, 0, 4'd15, 0);               // R4 N=2 just too big
        do_op(32'd4, 32'hFFFF_FFFE, 1, 0, 4'd15, 0);       // R6 N=2 quotient -2 fits
        do_op(32'd4, 32'd2, 1, 0, 4'd15, 0);               // R6 N=2 quotient 2 overflows
        do_op(32'd5000, 32'd3, 0, 0, 4'd4, 1);             // R9 start ignored while busy

        // boundary of quotient range for each length (R2, R4, R6)
        for (int st = 0; st < 16; st++) begin
            int n;
            n = qlen(4'(st));
            if (n < 32) begin
                do_op(32'((longint'(1) <<< n) * 3 - 1), 32'd3, 0, 0, 4'(st), 0);
                do_op(32'((longint'(1) <<< n) * 3), 32'd3, 0, 0, 4'(st), 0);
                do_op(32'(-((longint'(1) <<< (n - 1)) * 5)), 32'd5, 1, 0, 4'(st), 0);
                do_op(32'((longint'(1) <<< (n - 1)) * 5), 32'd5, 1, 0, 4'(st), 0);
            end
        end

        // random operands over every mode and length
        for (int st = 0; st < 16; st++) begin
            for (int md = 0; md < 4; md++) begin
                for (int k = 0; k < 6; k++) begin
                    logic [31:0] ra, rb;
                    ra = $urandom() >> ($urandom() % 32);
                    rb = $urandom() >> ($urandom() % 32);
                    if (k == 0) rb = '0;
                    if (k == 1 && md[0]) ra = -ra;
                    if (k == 2 && md[0]) rb = -rb;
                    do_op(ra, rb, md[0], md[1], 4'(st), 0);
                end
            end
        end

        // reset in the middle of a division (R1)
        @(negedge clk);
        dividend = 32'd999; divisor = 32'd4; signed_mode = 0; half_sel = 0;
        step_sel = 4'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state();                               // R1
        rst_n = 1'b1;
        do_op(32'd81, 32'd9, 0, 0, 4'd0, 0);               // R3 after reset
        finish_run();
    end
endmodule